// File: doc/BRIEF.md
# Block Floating Point Normalizer

This block gathers a block of signed two's-complement samples and finds one exponent that all of them share. The samples arrive one per cycle over a valid/ready handshake, and a start marker opens each block. As each sample is accepted, the block stores it in a local buffer and folds its sign-corrected magnitude into a running OR. When the last sample of the block has been accepted, the block counts the redundant sign bits of that OR. The count is the number of left shifts that brings the largest-magnitude member to the full range of the datapath.

The block then plays the stored samples back in arrival order. Each sample is shifted left by the shared count and is presented together with the count and an end-of-block marker. Only one buffer is present, so the input side stalls while a block is being played back. A downstream stage takes the shifted samples as plain fixed-point values and keeps the exponent to scale its later results.

Top module: `bfp_normalizer`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A transfer with `in_first` = 1 opens a new block at position 0 and drops any partly gathered block. A transfer with `in_first` = 0 while no block is open is discarded and has no effect on any later result.
- R3: `out_valid` rises in the cycle after the transfer that completes the block (the BLOCK_LEN-th sample). The samples then leave in arrival order, and `out_last` = 1 only on the BLOCK_LEN-th output.
- R4: For each sample, count the consecutive bits just below the sign bit that are equal to the sign bit. `out_exp` is the smallest of these counts over the block, which is the count set by the largest-magnitude member. It stays constant for the whole block.
- R5: Each `out_data` equals the stored sample shifted left by `out_exp`, with zeros filled in at the bottom. Shifting it back arithmetically by `out_exp` gives the original sample again, so no output overflows.
- R6: A block that is all zero gives `out_exp` = SAMPLE_W-1, and every output is zero.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_data`, `out_exp` and `out_last` hold their values and `out_valid` stays 1.
- R8: `in_ready` is 0 from the cycle after the block completes until the final output has been accepted. In the next cycle `in_ready` returns to 1 and `out_valid` falls to 0.
- R9: A block that contains the most negative code (only the sign bit set) gives `out_exp` = 0, and every sample passes through unchanged.
- R10: Input transfers offered while `in_ready` = 0 are ignored. The block being played back is not changed, and the next block's result does not depend on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input sample is offered |
| in_ready | output | 1 | The block can accept a sample |
| in_first | input | 1 | The offered sample opens a new block |
| in_data | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | A normalized sample is presented |
| out_ready | input | 1 | The consumer accepts the presented sample |
| out_data | output | SAMPLE_W | Sample shifted left by the shared exponent |
| out_exp | output | EXP_W | Shared left-shift count of the block |
| out_last | output | 1 | Final sample of the block |

## Verification
Some cases are hard to reach from the ports: a block abandoned halfway by a fresh start marker, a stray sample with no open block, and input traffic offered during playback. Random stimulus almost never produces them. Directed sequences build each case on purpose. Each stray or dropped sample is chosen so large that it would have lowered the exponent if it had been taken, which makes any leak visible in the outputs. The random blocks scale every block by a random shift, so the exponent covers its whole range. Random `out_ready` stalls hold playback for varying spans.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_REPLAY = 1'b1
  } bfp_state_e;
endpackage

// File: rtl/bfp_sample_buf.sv
module bfp_sample_buf #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/bfp_exp_tracker.sv
module bfp_exp_tracker #(
  parameter int W     = 16,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic             close,
  input  logic [W-1:0]     in_data,
  output logic [EXP_W-1:0] exp_q
);
  // Fold a negative value onto its one's complement so that its
  // redundant sign bits become leading zeros.
  function automatic logic [W-1:0] fold_mag(input logic [W-1:0] v);
    return v ^ {W{v[W-1]}};
  endfunction

  // Leading zeros of bits W-2..0; an empty word gives W-1.
  function automatic logic [EXP_W-1:0] lead_zeros(input logic [W-1:0] v);
    logic [EXP_W-1:0] n;
    n = EXP_W'(W - 1);
    for (int i = 0; i < W - 1; i++) begin
      if (v[i]) n = EXP_W'(W - 2 - i);
    end
    return n;
  endfunction

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_next;

  assign acc_next = (restart ? '0 : acc_q) | fold_mag(in_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      exp_q <= '0;
    end else if (take) begin
      acc_q <= acc_next;
      if (close) exp_q <= lead_zeros(acc_next);
    end
  end
endmodule

// File: rtl/bfp_ctrl.sv
module bfp_ctrl
  import bfp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             take,
  output logic             restart,
  output logic             blk_done,
  output logic             drain_done,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  bfp_state_e       state_q;
  logic             open_q;
  logic [IDX_W-1:0] cnt_q;

  assign in_ready   = (state_q == ST_GATHER);
  assign out_valid  = (state_q == ST_REPLAY);
  assign out_last   = out_valid && (rd_idx == LAST_IDX);
  assign take       = in_valid && in_ready && (in_first || open_q);
  assign restart    = in_first;
  assign wr_idx     = in_first ? '0 : cnt_q;
  assign blk_done   = take && (wr_idx == LAST_IDX);
  assign drain_done = out_valid && out_ready && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      open_q  <= 1'b0;
      cnt_q   <= '0;
      rd_idx  <= '0;
    end else begin
      case (state_q)
        ST_GATHER: begin
          if (take) begin
            cnt_q  <= wr_idx + 1'b1;
            open_q <= !blk_done;
          end
          if (blk_done) begin
            state_q <= ST_REPLAY;
            rd_idx  <= '0;
            cnt_q   <= '0;
          end
        end
        ST_REPLAY: begin
          if (out_ready) rd_idx <= rd_idx + 1'b1;
          if (drain_done) state_q <= ST_GATHER;
        end
        default: state_q <= ST_GATHER;
      endcase
    end
  end
endmodule

// File: rtl/bfp_normalizer.sv
module bfp_normalizer #(
  parameter int SAMPLE_W  = 16,
  parameter int BLOCK_LEN = 8,
  localparam int EXP_W    = $clog2(SAMPLE_W),
  localparam int IDX_W    = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_first,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic [EXP_W-1:0]    out_exp,
  output logic                out_last
);
  function automatic logic [SAMPLE_W-1:0] scale_up(input logic [SAMPLE_W-1:0] v,
                                                   input logic [EXP_W-1:0] sh);
    return v << sh;
  endfunction

  logic             take;
  logic             restart;
  logic             blk_done;
  logic             drain_done;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [SAMPLE_W-1:0] rd_sample;

  bfp_ctrl #(.DEPTH(BLOCK_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_last(out_last), .take(take), .restart(restart), .blk_done(blk_done),
    .drain_done(drain_done), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  bfp_sample_buf #(.W(SAMPLE_W), .DEPTH(BLOCK_LEN), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .wr_en(take), .wr_idx(wr_idx), .wr_data(in_data),
    .rd_idx(rd_idx), .rd_data(rd_sample)
  );

  bfp_exp_tracker #(.W(SAMPLE_W), .EXP_W(EXP_W)) u_exp (
    .clk(clk), .rst_n(rst_n), .take(take), .restart(restart),
    .close(blk_done), .in_data(in_data), .exp_q(out_exp)
  );

  assign out_data = scale_up(rd_sample, out_exp);
endmodule

// File: rtl/bfp_normalizer_sva.sv
module bfp_normalizer_sva #(
  parameter int W     = 16,
  parameter int EXP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_data,
  input logic [EXP_W-1:0] out_exp,
  input logic             out_last,
  input logic [W-1:0]     rd_sample,
  input logic             blk_done,
  input logic             drain_done
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_idle_r1: assert (!out_valid && in_ready)
        else $error("reset state wrong");
    end
  end

  p_replay_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> out_valid);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($signed(out_data) >>> out_exp) == $signed(rd_sample)));

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_exp) && $stable(out_last));

  p_exp_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !drain_done |=> $stable(out_exp));

  p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |=> in_ready && !out_valid);
endmodule

bind bfp_normalizer bfp_normalizer_sva #(.W(SAMPLE_W), .EXP_W(EXP_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_exp(out_exp),
  .out_last(out_last), .rd_sample(rd_sample), .blk_done(blk_done),
  .drain_done(drain_done)
);

// File: tb/tb_bfp_normalizer.sv
module tb_bfp_normalizer;
  localparam int W  = 16;
  localparam int N  = 8;
  localparam int EW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [W-1:0] out_data;
  logic [EW-1:0] out_exp;

  int n_checks = 0, n_fail = 0;
  logic [W-1:0] blk [N];

  always #5 clk = ~clk;

  bfp_normalizer #(.SAMPLE_W(W), .BLOCK_LEN(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_exp(out_exp),
    .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Largest k for which shifting left by k and back restores the value.
  function automatic int headroom(input logic [W-1:0] v);
    logic signed [W-1:0] s;
    s = v;
    for (int k = W - 1; k > 0; k--) begin
      if (((s <<< k) >>> k) == s) return k;
    end
    return 0;
  endfunction

  function automatic int block_exp();
    int m = W - 1;
    for (int i = 0; i < N; i++) if (headroom(blk[i]) < m) m = headroom(blk[i]);
    return m;
  endfunction

  task automatic push(input logic [W-1:0] d, input bit first);
    in_valid = 1'b1; in_first = first; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  // Sends blk[] as a block, then drains it with random stalls.
  task automatic run_block(input bit junk);
    int e;
    int k;
    bit rdy;
    e = block_exp();
    for (int i = 0; i < N; i++) begin
      check(in_ready === 1'b1, "R8", "in_ready while gathering", in_ready, 1);
      in_valid = 1'b1; in_first = (i == 0); in_data = blk[i];
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0;
    check(out_valid === 1'b1, "R3", "out_valid after block", out_valid, 1);
    k = 0;
    while (k < N) begin
      rdy = ($urandom % 3) != 0;
      out_ready = rdy;
      if (junk) begin
        in_valid = 1'b1; in_first = 1'b1; in_data = 16'h4000;
      end
      check(out_valid === 1'b1, "R7", "valid held", out_valid, 1);
      check(in_ready === 1'b0, "R8", "in_ready during replay", in_ready, 0);
      check(out_data === W'(blk[k] << e), "R5", "out_data", out_data, W'(blk[k] << e));
      check(out_exp === EW'(e), "R4", "out_exp", out_exp, e);
      check(out_last === (k == N - 1), "R3", "out_last", out_last, (k == N - 1));
      @(posedge clk); @(negedge clk);
      if (rdy) k++;
    end
    in_valid = 1'b0; in_first = 1'b0; out_ready = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R8", "reopen after drain",
          {out_valid, in_ready}, 2'b01);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1", "in reset",
          {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R1", "after reset",
          {out_valid, in_ready}, 2'b01);

    // R6: all zero
    for (int i = 0; i < N; i++) blk[i] = '0;
    run_block(0);
    // R9: most negative code present
    for (int i = 0; i < N; i++) blk[i] = W'(i * 3 - 5);
    blk[4] = 16'h8000;
    run_block(0);
    // all minus one: largest shift, output becomes most negative code
    for (int i = 0; i < N; i++) blk[i] = 16'hFFFF;
    run_block(0);
    // single one among zeros
    for (int i = 0; i < N; i++) blk[i] = '0;
    blk[N-1] = 16'h0001;
    run_block(0);

    // R2: stray sample with no open block is dropped
    push(16'h4000, 1'b0);
    for (int i = 0; i < N; i++) blk[i] = W'(i + 1);
    run_block(0);

    // R2: partial block abandoned by a new start marker
    push(16'h6000, 1'b1);
    push(16'hA000, 1'b0);
    push(16'h5000, 1'b0);
    for (int i = 0; i < N; i++) blk[i] = W'($signed(i) - 4) <<< 2;
    run_block(0);

    // R10: traffic offered during replay is ignored
    for (int i = 0; i < N; i++) blk[i] = W'(i * 7);
    run_block(1);
    for (int i = 0; i < N; i++) blk[i] = W'(i);
    run_block(0);

    // random blocks of random scale
    for (int b = 0; b < 30; b++) begin
      int sh = $urandom % W;
      for (int i = 0; i < N; i++)
        blk[i] = W'($signed(W'($urandom)) >>> (sh + ($urandom % 3)));
      run_block(b % 5 == 0);
    end

    finish_run();
  end
endmodule